// File: doc/BRIEF.md
# Seven-to-one display lane mapper

This block turns a 27-bit parallel pixel (8-bit red, green and blue plus vertical sync, horizontal sync and data-enable) into four 7-bit serial data lanes and one 7-bit clock lane. Every lane sends seven bits per pixel, one bit on each pulse of a bit-rate enable. The enable comes from a fast clock seven times the pixel rate. The pixel clock arrives as a level that is sampled in the fast clock domain, and a select input picks whether the rising or the falling pixel-clock edge captures the pixel word.

Two bit layouts are available. The layout with `map_sel` = 1 puts the upper six bits of each colour on the first three lanes and the two lowest bits on the fourth lane. The layout with `map_sel` = 0 puts the lower six bits on the first three lanes and the two highest bits on the fourth lane. Both layouts share lane C with blue and the three flags. In 18-bit mode the fourth lane is switched off. Outputs are plain logic bits, and each lane has an enable that stands for high impedance.

A slot sequencer steps through the states ST_IDLE, ST_SLOT1, ST_SLOT0, ST_SLOT6, ST_SLOT5, ST_SLOT4, ST_SLOT3 and ST_SLOT2. Each step happens on a bit enable while powered up. The transitions are: ST_IDLE→ST_SLOT1 (load), ST_SLOT1→ST_SLOT0→ST_SLOT6→ST_SLOT5→ST_SLOT4→ST_SLOT3→ST_SLOT2 (shift), ST_SLOT2→ST_SLOT1 (load), and any state→ST_IDLE while powered down.

Top module: `pix_lane_serializer`

## Requirements
- R1: After reset every data lane bit and the clock lane bit are 0 and all five enables are 1 (powered up, drivers on). No pixel appears on the lanes before the first bit enable, even if a pixel was captured.
- R2: Each bit enable moves every lane one slot, in the serial order slot 1, slot 0, slot 6, 5, 4, 3, 2. Without a bit enable the lane outputs do not change.
- R3: With map_sel=1 the slots (6..0) are as follows. Lane A (ser_dat[0]) = G2,R7,R6,R5,R4,R3,R2. Lane B (ser_dat[1]) = B3,B2,G7,G6,G5,G4,G3. Lane C (ser_dat[2]) = DE,VSYNC,HSYNC,B7,B6,B5,B4. Lane D (ser_dat[3]) = 0,B1,B0,G1,G0,R1,R0.
- R4: With map_sel=0 the slots (6..0) are as follows. Lane A = G0,R5..R0. Lane B = B1,B0,G5..G1. Lane C = DE,VSYNC,HSYNC,B5..B2. Lane D = 0,B7,B6,G7,G6,R7,R6.
- R5: The clock lane (ser_clk) sends 1,1,0,0,0,1,1 over the seven slots of each pixel, in serial order.
- R6: A new pixel word is loaded on the bit enable that follows the slot-2 bit. The first bit after that is slot 1 of the new pixel, with no gap.
- R7: With edge_sel=1 a 0→1 change of pix_clk captures the pixel inputs. With edge_sel=0 a 1→0 change captures them. The other edge has no effect on the pixel that is sent.
- R8: With six_bit=1, ser_oe[3] and ser_dat[3] are 0, while lanes A to C and the clock lane keep their mapping and enables.
- R9: With pwr_up=0 or drv_en=0, all five enables, all data bits and the clock bit are 0. While pwr_up=0 the sequencer returns to idle, so the next bit enable after power-up starts a fresh pixel at slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (seven times pixel rate or faster) |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable, one pulse per serial bit |
| pix_clk | input | 1 | Pixel clock level, sampled on clk |
| edge_sel | input | 1 | 1: capture on pix_clk rising, 0: on falling |
| map_sel | input | 1 | Bit layout select (see R3, R4) |
| six_bit | input | 1 | 1: 18-bit mode, lane D disabled |
| pwr_up | input | 1 | 0: power down, all lanes off |
| drv_en | input | 1 | 0: all lane drivers off |
| red | input | 8 | Red component |
| grn | input | 8 | Green component |
| blu | input | 8 | Blue component |
| vsync | input | 1 | Vertical sync flag |
| hsync | input | 1 | Horizontal sync flag |
| de | input | 1 | Data-enable flag |
| ser_dat | output | 4 | Serial data lanes A..D (bit 0 = A) |
| ser_clk | output | 1 | Serial clock lane |
| ser_oe | output | 5 | Lane enables, bits 3..0 data lanes, bit 4 clock lane |

## Verification
The assertions check on every cycle that the sequencer holds still without a bit enable and wraps from slot 2 to slot 1. They also check that the clock lane level matches the slot state, that power-down or driver-off silences every lane and power-down forces idle, and that 18-bit mode keeps lane D off. The placement of each pixel bit in both layouts, the capture edge choice, the order in which bits leave the lanes, and the restart at slot 1 after a power-down in mid-pixel only show in the bench's scenarios. Those scenarios sweep walking-one and mixed pixels over every combination of layout, 18-bit mode and capture edge.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int COLOR_W   = 8;
    localparam int DATA_LN   = 4;
    localparam int ALL_LN    = DATA_LN + 1;
    localparam int SLOT_N    = 7;
    localparam int PIX_W     = 3 * COLOR_W + 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT1,
        ST_SLOT0,
        ST_SLOT6,
        ST_SLOT5,
        ST_SLOT4,
        ST_SLOT3,
        ST_SLOT2
    } slot_t;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               vs;
        logic               hs;
        logic               de;
    } pixel_t;

    // clock lane pattern, first-sent bit in the MSB
    localparam logic [SLOT_N-1:0] CLK_SERIAL = 7'b1100011;
endpackage

// File: rtl/pls_lane_mapper.sv
module pls_lane_mapper
    import pls_pkg::*;
(
    input  pixel_t                               pix,
    input  logic                                 map_sel,
    output logic [DATA_LN-1:0][SLOT_N-1:0]       slots
);
    always_comb begin
        if (map_sel) begin
            slots[0] = {pix.grn[2], pix.red[7:2]};
            slots[1] = {pix.blu[3:2], pix.grn[7:3]};
            slots[2] = {pix.de, pix.vs, pix.hs, pix.blu[7:4]};
            slots[3] = {1'b0, pix.blu[1:0], pix.grn[1:0], pix.red[1:0]};
        end else begin
            slots[0] = {pix.grn[0], pix.red[5:0]};
            slots[1] = {pix.blu[1:0], pix.grn[5:1]};
            slots[2] = {pix.de, pix.vs, pix.hs, pix.blu[5:2]};
            slots[3] = {1'b0, pix.blu[7:6], pix.grn[7:6], pix.red[7:6]};
        end
    end
endmodule

// File: rtl/pls_edge_capture.sv
module pls_edge_capture
    import pls_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pix_clk,
    input  logic   edge_sel,
    input  pixel_t pix_in,
    output pixel_t pix_hold
);
    logic pclk_q;
    logic take;

    always_comb begin
        if (edge_sel) take = pix_clk & ~pclk_q;
        else          take = ~pix_clk & pclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_q   <= 1'b0;
            pix_hold <= '0;
        end else begin
            pclk_q <= pix_clk;
            if (take) pix_hold <= pix_in;
        end
    end
endmodule

// File: rtl/pls_slot_fsm.sv
module pls_slot_fsm
    import pls_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  logic  pwr_up,
    output slot_t state,
    output logic  load,
    output logic  shift
);
    slot_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        if (!pwr_up) begin
            nxt = ST_IDLE;
        end else if (bit_en) begin
            unique case (state)
                ST_IDLE:  begin nxt = ST_SLOT1; load = 1'b1; end
                ST_SLOT1: nxt = ST_SLOT0;
                ST_SLOT0: nxt = ST_SLOT6;
                ST_SLOT6: nxt = ST_SLOT5;
                ST_SLOT5: nxt = ST_SLOT4;
                ST_SLOT4: nxt = ST_SLOT3;
                ST_SLOT3: nxt = ST_SLOT2;
                ST_SLOT2: begin nxt = ST_SLOT1; load = 1'b1; end
            endcase
        end
        shift = pwr_up & bit_en & ~load;
    end
endmodule

// File: rtl/pls_lane_shift.sv
module pls_lane_shift
    import pls_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pwr_up,
    input  logic                            load,
    input  logic                            shift,
    input  logic [ALL_LN-1:0][SLOT_N-1:0]   par,
    output logic [ALL_LN-1:0]               sbit
);
    for (genvar ln = 0; ln < ALL_LN; ln++) begin : g_lane
        logic [SLOT_N-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sh <= '0;
            else if (!pwr_up) sh <= '0;
            else if (load)   sh <= par[ln];
            else if (shift)  sh <= {sh[SLOT_N-2:0], 1'b0};
        end
        assign sbit[ln] = sh[SLOT_N-1];
    end
endmodule

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer
    import pls_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               pix_clk,
    input  logic               edge_sel,
    input  logic               map_sel,
    input  logic               six_bit,
    input  logic               pwr_up,
    input  logic               drv_en,
    input  logic [7:0]         red,
    input  logic [7:0]         grn,
    input  logic [7:0]         blu,
    input  logic               vsync,
    input  logic               hsync,
    input  logic               de,
    output logic [3:0]         ser_dat,
    output logic               ser_clk,
    output logic [4:0]         ser_oe
);
    pixel_t                           pix_in;
    pixel_t                           pix_hold;
    logic [DATA_LN-1:0][SLOT_N-1:0]   slot_map;
    logic [ALL_LN-1:0][SLOT_N-1:0]    par;
    logic [ALL_LN-1:0]                sbit;
    slot_t                            slot_st;
    logic                             load;
    logic                             shift;
    logic                             lane_live;

    assign pix_in = '{red: red, grn: grn, blu: blu, vs: vsync, hs: hsync, de: de};

    pls_edge_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_clk  (pix_clk),
        .edge_sel (edge_sel),
        .pix_in   (pix_in),
        .pix_hold (pix_hold)
    );

    pls_lane_mapper u_map (
        .pix     (pix_hold),
        .map_sel (map_sel),
        .slots   (slot_map)
    );

    // reorder each lane into send order: slot 1, 0, 6, 5, 4, 3, 2
    for (genvar ln = 0; ln < DATA_LN; ln++) begin : g_order
        assign par[ln] = {slot_map[ln][1], slot_map[ln][0], slot_map[ln][6:2]};
    end
    assign par[DATA_LN] = CLK_SERIAL;

    pls_slot_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .pwr_up (pwr_up),
        .state  (slot_st),
        .load   (load),
        .shift  (shift)
    );

    pls_lane_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_up (pwr_up),
        .load   (load),
        .shift  (shift),
        .par    (par),
        .sbit   (sbit)
    );

    // output process: enables and masking
    always_comb begin
        lane_live = pwr_up & drv_en;
        for (int ln = 0; ln < DATA_LN; ln++) begin
            ser_oe[ln]  = lane_live & ~(six_bit && ln == DATA_LN - 1);
            ser_dat[ln] = sbit[ln] & ser_oe[ln];
        end
        ser_oe[DATA_LN] = lane_live;
        ser_clk         = sbit[DATA_LN] & lane_live;
    end
endmodule

// File: rtl/pls_checker.sv
module pls_checker
    import pls_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       pwr_up,
    input logic       drv_en,
    input logic       six_bit,
    input logic [3:0] ser_dat,
    input logic       ser_clk,
    input logic [4:0] ser_oe,
    input slot_t      state
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && pwr_up) |=> $stable(state));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pwr_up && state == ST_SLOT2) |=> (state == ST_SLOT1));

    p_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && drv_en && (state == ST_SLOT6 || state == ST_SLOT5 || state == ST_SLOT4))
        |-> !ser_clk);

    p_clk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && drv_en && (state == ST_SLOT1 || state == ST_SLOT0 ||
                              state == ST_SLOT3 || state == ST_SLOT2))
        |-> ser_clk);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!ser_clk && ser_dat == 4'd0));

    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_up || !drv_en) |-> (ser_oe == 5'd0 && ser_dat == 4'd0 && !ser_clk));

    p_pd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> (state == ST_IDLE));

    p_six_r8: assert property (@(posedge clk) disable iff (!rst_n)
        six_bit |-> (!ser_oe[3] && !ser_dat[3]));
endmodule

bind pix_lane_serializer pls_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .pwr_up  (pwr_up),
    .drv_en  (drv_en),
    .six_bit (six_bit),
    .ser_dat (ser_dat),
    .ser_clk (ser_clk),
    .ser_oe  (ser_oe),
    .state   (slot_st)
);

// File: tb/pix_lane_serializer_tb.sv
`timescale 1ns/1ps
module pix_lane_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, pix_clk = 1'b0, edge_sel = 1'b1, map_sel = 1'b1;
    logic       six_bit = 1'b0, pwr_up = 1'b1, drv_en = 1'b1;
    logic [26:0] pin = '0;
    logic [3:0] ser_dat;
    logic       ser_clk;
    logic [4:0] ser_oe;
    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pix_lane_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pix_clk(pix_clk),
        .edge_sel(edge_sel), .map_sel(map_sel), .six_bit(six_bit),
        .pwr_up(pwr_up), .drv_en(drv_en),
        .red(pin[7:0]), .grn(pin[15:8]), .blu(pin[23:16]),
        .vsync(pin[24]), .hsync(pin[25]), .de(pin[26]),
        .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_oe(ser_oe)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected slot bit from layout arithmetic; v = {de,hs,vs,blu,grn,red}
    function automatic logic exp_slot(int ln, int s, logic [26:0] v, logic m);
        logic [7:0] r, g, b;
        int o, base;
        r = v[7:0]; g = v[15:8]; b = v[23:16];
        o = m ? 2 : 0;
        base = m ? 0 : 6;
        case (ln)
            0: return (s == 6) ? g[o] : r[s+o];
            1: return (s >= 5) ? b[s-5+o] : g[s+1+o];
            2: return (s == 6) ? v[26] : (s == 5) ? v[24] : (s == 4) ? v[25] : b[s+2+o];
            default: return (s == 6) ? 1'b0 : (s >= 4) ? b[base+s-4] :
                            (s >= 2) ? g[base+s-2] : r[base+s];
        endcase
    endfunction

    task automatic pulse();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    task automatic capture(logic [26:0] v, logic es);
        edge_sel = es;
        if (es) begin
            @(negedge clk) begin pin = v; pix_clk = 1'b1; end
            @(negedge clk) begin pin = ~v; pix_clk = 1'b0; end   // falling ignored (R7)
        end else begin
            @(negedge clk) begin pin = ~v; pix_clk = 1'b1; end   // rising ignored (R7)
            @(negedge clk) begin pin = v; pix_clk = 1'b0; end
        end
        @(negedge clk) pin = ~v;
    endtask

    task automatic run_frame(logic [26:0] v, logic m, logic six, logic en, string tag);
        int ord[7] = '{1, 0, 6, 5, 4, 3, 2};
        logic [4:0] eoe;
        logic [3:0] edat;
        logic [3:0] keep;
        logic       kclk;
        eoe = {en, en & ~six, en, en, en};
        for (int k = 0; k < 7; k++) begin
            pulse();
            for (int ln = 0; ln < 4; ln++) edat[ln] = eoe[ln] & exp_slot(ln, ord[k], v, m);
            chk({tag, " R2 R6 lanes"}, {28'd0, ser_dat}, {28'd0, edat});
            chk("R5 clock lane", {31'd0, ser_clk}, {31'd0, en & (k < 2 || k > 4)});
            chk("R8 R9 enables", {27'd0, ser_oe}, {27'd0, eoe});
            if (k == 3) begin
                keep = ser_dat; kclk = ser_clk;
                repeat (2) @(negedge clk);
                chk("R2 hold without enable", {27'd0, ser_dat, ser_clk}, {27'd0, keep, kclk});
            end
        end
    endtask

    initial begin
        logic [26:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset data", {28'd0, ser_dat}, 32'd0);
        chk("R1 reset clock", {31'd0, ser_clk}, 32'd0);
        chk("R1 reset enables", {27'd0, ser_oe}, 32'h1F);
        capture(27'h5A5A5A5, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 no load before bit enable", {27'd0, ser_dat, ser_clk}, 32'd0);
        run_frame(27'h5A5A5A5, 1'b1, 1'b0, 1'b1, "R3");

        for (int m = 0; m < 2; m++)
            for (int six = 0; six < 2; six++)
                for (int es = 0; es < 2; es++)
                    for (int p = 0; p < 31; p++) begin
                        v = (p < 27) ? (27'd1 << p) : 27'((p * 32'h2545F491) ^ 32'h05A3C96F);
                        map_sel = m[0];
                        six_bit = six[0];
                        capture(v, es[0]);
                        run_frame(v, m[0], six[0], 1'b1,
                                  es[0] ? (m[0] ? "R3" : "R4") : (m[0] ? "R3 R7" : "R4 R7"));
                    end

        six_bit = 1'b0; map_sel = 1'b1;
        drv_en = 1'b0;
        capture(27'h7FFFFFF, 1'b1);
        run_frame(27'h7FFFFFF, 1'b1, 1'b0, 1'b0, "R9 drivers off");
        drv_en = 1'b1;

        capture(27'h3C3C3C3, 1'b1);
        pulse(); pulse(); pulse();
        @(negedge clk) pwr_up = 1'b0;
        @(negedge clk);
        chk("R9 power down silent", {27'd0, ser_oe}, 32'd0);
        chk("R9 power down data", {27'd0, ser_dat, ser_clk}, 32'd0);
        @(negedge clk) pwr_up = 1'b1;
        capture(27'h1234567, 1'b0);
        run_frame(27'h1234567, 1'b1, 1'b0, 1'b1, "R9 restart R3");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule